// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps the time of day and the calendar as packed BCD bytes and moves them forward by one second on each single-cycle `tick` pulse. The fields are seconds, minutes, hours (24-hour form), date, month, two-digit year, a weekday counter and a century byte. Carries ripple through the chain in the same clock as the tick, so every field has its new value one clock after the tick is sampled.

A host loads any one field through a narrow write port: `wr_en` with a field select and a data byte. All eight fields are always visible on dedicated read buses. The weekday runs on its own and is not derived from the date. It steps once for every day rollover. The century byte moves from 19 to 20 when the year wraps.

The design does not use a state machine. The entire timekeeping state is the eight field registers. Each register is advanced by the shared carry chain or loaded by the host.

Top module: `bcd_clock_cal`

## Requirements
- R1: After reset, seconds, minutes, hours, year and weekday read 00h, date and month read 01h, and the century reads 20h.
- R2: A cycle with `tick` high and no write increments seconds in BCD. Seconds wrap from 59h to 00h and carry one into minutes. A cycle with neither tick nor write leaves every field unchanged.
- R3: Minutes wrap from 59h to 00h and carry into hours. Hours count 00h to 23h, and the wrap from 23h to 00h is a day rollover.
- R4: On a day rollover, the date wraps to 01h after the last day of the month and carries into the month. Months 04h, 06h, 09h and 11h have 30 days, February has 28 days in a non-leap year, and all other months have 31.
- R5: February has 29 days when the two-digit BCD year is divisible by four, including year 00h.
- R6: Month wraps from 12h to 01h and carries into the year. The year wraps from 99h to 00h. On that wrap a century of 19h becomes 20h, and a century of 20h stays 20h.
- R7: The weekday (bits 2:0, upper bits zero) increments on every day rollover and wraps from 6 to 0. Writes to other fields never change it.
- R8: Field select codes are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 weekday and 7 century. A write is visible on the next clock and is masked per field: seconds and minutes keep bits 6:0, hours and date keep bits 5:0, month keeps bits 4:0, weekday keeps bits 2:0, and year and century keep all eight bits. Masked bits read as zero.
- R9: A field written in the same cycle as a tick takes the written value and ignores the tick. It also passes no carry to the next field.
- R10: A date written beyond the current month's last day rolls over to 01h at the next day rollover and carries into the month.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse, one per second |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Field select for the write (R8 encoding) |
| wr_data | input | 8 | Write data byte |
| rd_sec | output | 8 | Seconds, BCD |
| rd_min | output | 8 | Minutes, BCD |
| rd_hour | output | 8 | Hours, BCD, 24-hour |
| rd_date | output | 8 | Day of month, BCD |
| rd_month | output | 8 | Month, BCD |
| rd_year | output | 8 | Two-digit year, BCD |
| rd_dow | output | 8 | Weekday 0 to 6 in bits 2:0 |
| rd_cent | output | 8 | Century, BCD 19h or 20h |

## Verification
The bench builds the block with its default parameters: a seven-day week, 19h as the old century and 20h as both the new and the reset century. Host writes preload each corner directly, for example 23:59:59 on the last day of a month, or 31 December 99 with century 19h. This puts every wrap, every month length, both leap cases and the century step within a few cycles. The same-cycle tick and write cases are driven directly, and the weekday is tracked across all the rollovers that the scenarios cause.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

    typedef enum logic [2:0] {
        SEL_SEC   = 3'd0,
        SEL_MIN   = 3'd1,
        SEL_HOUR  = 3'd2,
        SEL_DATE  = 3'd3,
        SEL_MONTH = 3'd4,
        SEL_YEAR  = 3'd5,
        SEL_DOW   = 3'd6,
        SEL_CENT  = 3'd7
    } field_sel_e;

    localparam int CHAIN_LEN = 6;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) begin
            r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

    function automatic logic [7:0] field_mask(input int idx);
        logic [7:0] m;
        case (idx)
            0, 1:    m = 8'h7F;
            2, 3:    m = 8'h3F;
            4:       m = 8'h1F;
            default: m = 8'hFF;
        endcase
        return m;
    endfunction

    function automatic logic [7:0] field_first(input int idx);
        logic [7:0] m;
        case (idx)
            3, 4:    m = 8'h01;
            default: m = 8'h00;
        endcase
        return m;
    endfunction

    function automatic logic [7:0] field_last(input int idx);
        logic [7:0] m;
        case (idx)
            0, 1:    m = 8'h59;
            2:       m = 8'h23;
            4:       m = 8'h12;
            5:       m = 8'h99;
            default: m = 8'h31;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bcdcal_field.sv
module bcdcal_field
    import bcdcal_pkg::*;
#(
    parameter logic [7:0] RST_VAL = 8'h00,
    parameter logic [7:0] MIN_VAL = 8'h00,
    parameter logic [7:0] MASK    = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld,
    input  logic [7:0] ld_val,
    input  logic       step,
    input  logic [7:0] last,
    output logic [7:0] val,
    output logic       carry
);

    logic at_end;
    logic [7:0] nxt;

    always_comb begin
        at_end = (val >= last);
        carry  = step & ~ld & at_end;
        if (ld) begin
            nxt = ld_val & MASK;
        end else if (step) begin
            nxt = at_end ? MIN_VAL : (bcd_inc(val) & MASK);
        end else begin
            nxt = val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val <= RST_VAL;
        end else begin
            val <= nxt;
        end
    end

endmodule

// File: rtl/bcdcal_month_len.sv
module bcdcal_month_len (
    input  logic [7:0] month,
    input  logic [7:0] year,
    output logic [7:0] last_day
);

    logic leap;

    always_comb begin
        if (year[4]) begin
            leap = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
        end else begin
            leap = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) || (year[3:0] == 4'd8);
        end
        unique case (month)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end

endmodule

// File: rtl/bcdcal_aux.sv
module bcdcal_aux #(
    parameter int         DAYS_PER_WEEK = 7,
    parameter logic [7:0] CENT_RST      = 8'h20,
    parameter logic [7:0] CENT_OLD      = 8'h19,
    parameter logic [7:0] CENT_NEW      = 8'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       day_roll,
    input  logic       year_roll,
    input  logic       ld_dow,
    input  logic       ld_cent,
    input  logic [7:0] wr_data,
    output logic [7:0] dow,
    output logic [7:0] cent
);

    localparam int DOW_W = $clog2(DAYS_PER_WEEK);
    localparam logic [DOW_W-1:0] DOW_LAST = DOW_W'(DAYS_PER_WEEK - 1);

    logic [DOW_W-1:0] dow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dow_q <= '0;
        end else if (ld_dow) begin
            dow_q <= wr_data[DOW_W-1:0];
        end else if (day_roll) begin
            dow_q <= (dow_q >= DOW_LAST) ? '0 : dow_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cent <= CENT_RST;
        end else if (ld_cent) begin
            cent <= wr_data;
        end else if (year_roll && cent == CENT_OLD) begin
            cent <= CENT_NEW;
        end
    end

    assign dow = {{(8 - DOW_W){1'b0}}, dow_q};

endmodule

// File: rtl/bcd_clock_cal.sv
module bcd_clock_cal
    import bcdcal_pkg::*;
#(
    parameter int         DAYS_PER_WEEK = 7,
    parameter logic [7:0] CENT_RST      = 8'h20,
    parameter logic [7:0] CENT_OLD      = 8'h19,
    parameter logic [7:0] CENT_NEW      = 8'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_sec,
    output logic [7:0] rd_min,
    output logic [7:0] rd_hour,
    output logic [7:0] rd_date,
    output logic [7:0] rd_month,
    output logic [7:0] rd_year,
    output logic [7:0] rd_dow,
    output logic [7:0] rd_cent
);

    logic [7:0]         fval  [CHAIN_LEN];
    logic [7:0]         flast [CHAIN_LEN];
    logic [CHAIN_LEN:0] step_v;
    logic [7:0]         month_last;

    assign step_v[0] = tick;

    bcdcal_month_len u_mlen (
        .month    (fval[4]),
        .year     (fval[5]),
        .last_day (month_last)
    );

    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_chain
        if (i == 3) begin : g_dyn
            assign flast[i] = month_last;
        end else begin : g_fix
            assign flast[i] = field_last(i);
        end

        bcdcal_field #(
            .RST_VAL (field_first(i)),
            .MIN_VAL (field_first(i)),
            .MASK    (field_mask(i))
        ) u_fld (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (wr_en && (wr_sel == 3'(i))),
            .ld_val (wr_data),
            .step   (step_v[i]),
            .last   (flast[i]),
            .val    (fval[i]),
            .carry  (step_v[i+1])
        );
    end

    bcdcal_aux #(
        .DAYS_PER_WEEK (DAYS_PER_WEEK),
        .CENT_RST      (CENT_RST),
        .CENT_OLD      (CENT_OLD),
        .CENT_NEW      (CENT_NEW)
    ) u_aux (
        .clk       (clk),
        .rst_n     (rst_n),
        .day_roll  (step_v[3]),
        .year_roll (step_v[6]),
        .ld_dow    (wr_en && (wr_sel == SEL_DOW)),
        .ld_cent   (wr_en && (wr_sel == SEL_CENT)),
        .wr_data   (wr_data),
        .dow       (rd_dow),
        .cent      (rd_cent)
    );

    assign rd_sec   = fval[0];
    assign rd_min   = fval[1];
    assign rd_hour  = fval[2];
    assign rd_date  = fval[3];
    assign rd_month = fval[4];
    assign rd_year  = fval[5];

endmodule

// File: rtl/bcdcal_chk.sv
module bcdcal_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       wr_en,
    input logic [2:0] wr_sel,
    input logic [7:0] wr_data,
    input logic [7:0] rd_sec,
    input logic [7:0] rd_min,
    input logic [7:0] rd_hour,
    input logic [7:0] rd_date,
    input logic [7:0] rd_month,
    input logic [7:0] rd_year,
    input logic [7:0] rd_dow,
    input logic [7:0] rd_cent
);

    // R2
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !wr_en && rd_sec == 8'h59 |=> rd_sec == 8'h00);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !wr_en |=> $stable(rd_sec) && $stable(rd_min) && $stable(rd_hour)
            && $stable(rd_date) && $stable(rd_month) && $stable(rd_year)
            && $stable(rd_dow) && $stable(rd_cent));

    // R3
    hour_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !wr_en && rd_sec == 8'h59 && rd_min == 8'h59 && rd_hour == 8'h23
            |=> rd_hour == 8'h00);

    // R7
    dow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !wr_en && rd_sec == 8'h59 && rd_min == 8'h59 && rd_hour == 8'h23
            && rd_dow == 8'h06 |=> rd_dow == 8'h00);

    // R6
    cent_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !wr_en && rd_sec == 8'h59 && rd_min == 8'h59 && rd_hour == 8'h23
            && rd_date == 8'h31 && rd_month == 8'h12 && rd_year == 8'h99
            && rd_cent == 8'h19 |=> rd_cent == 8'h20 && rd_year == 8'h00);

    // R8
    sec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 3'd0 |=> rd_sec == ($past(wr_data) & 8'h7F));

    // R8
    msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_sec[7] && !rd_min[7] && rd_hour[7:6] == 2'b00 && rd_dow[7:3] == 5'd0);

    // R9
    min_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 3'd1 && tick |=> rd_min == ($past(wr_data) & 8'h7F));

endmodule

bind bcd_clock_cal bcdcal_chk u_chk (.*);

// File: tb/tb_bcd_clock_cal.sv
module tb_bcd_clock_cal;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_sec, rd_min, rd_hour, rd_date, rd_month, rd_year, rd_dow, rd_cent;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0]  e [8];
    logic [63:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    bcd_clock_cal dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sec(rd_sec), .rd_min(rd_min), .rd_hour(rd_hour), .rd_date(rd_date),
        .rd_month(rd_month), .rd_year(rd_year), .rd_dow(rd_dow), .rd_cent(rd_cent)
    );

    function automatic logic [63:0] pack_exp();
        return {e[0], e[1], e[2], e[3], e[4], e[5], e[6], e[7]};
    endfunction

    function automatic logic [7:0] mask_of(input logic [2:0] s);
        case (s)
            3'd0, 3'd1: return 8'h7F;
            3'd2, 3'd3: return 8'h3F;
            3'd4:       return 8'h1F;
            3'd6:       return 8'h07;
            default:    return 8'hFF;
        endcase
    endfunction

    task automatic drive(input logic t, input logic we, input logic [2:0] s,
                         input logic [7:0] d, input string tag);
        @(negedge clk);
        tick = t; wr_en = we; wr_sel = s; wr_data = d;
        @(posedge clk);
        #1;
        tick = 1'b0; wr_en = 1'b0;
        exp_q.push_back(pack_exp());
        tag_q.push_back(tag);
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d, input string tag);
        e[s] = d & mask_of(s);
        drive(1'b0, 1'b1, s, d, tag);
    endtask

    task automatic tk(input string tag);
        drive(1'b1, 1'b0, 3'd0, 8'h00, tag);
    endtask

    task automatic end_of_day(input string tag);
        wr(3'd0, 8'h59, tag);
        wr(3'd1, 8'h59, tag);
        wr(3'd2, 8'h23, tag);
    endtask

    task automatic new_day(input logic [7:0] d, input logic [7:0] m, input logic [7:0] dw);
        e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h00;
        e[3] = d; e[4] = m; e[6] = dw;
    endtask

    // monitor: compares outputs once the edge's results have settled
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            logic [63:0] want;
            logic [63:0] got;
            string       tg;
            want = exp_q.pop_front();
            tg   = tag_q.pop_front();
            got  = {rd_sec, rd_min, rd_hour, rd_date, rd_month, rd_year, rd_dow, rd_cent};
            checks++;
            if (got !== want) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", tg, got, want);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h00; e[3] = 8'h01;
        e[4] = 8'h01; e[5] = 8'h00; e[6] = 8'h00; e[7] = 8'h20;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        drive(1'b0, 1'b0, 3'd0, 8'h00, "R1 reset values");
        drive(1'b0, 1'b0, 3'd0, 8'h00, "R2 idle hold");
        e[0] = 8'h01; tk("R2 second increment");

        // R8 masking of seconds top bit
        wr(3'd0, 8'hD8, "R8 seconds write mask");
        e[0] = 8'h59; tk("R2 BCD step to 59");
        e[0] = 8'h00; e[1] = 8'h01; tk("R2 seconds wrap carries minutes");

        // R3 hours wrap, R7 weekday step
        end_of_day("R8 write");
        new_day(8'h02, 8'h01, 8'h01); tk("R3 R7 midnight rollover");

        // R4 thirty-day month
        wr(3'd4, 8'h04, "R8 month write");
        wr(3'd3, 8'h30, "R7 date write leaves weekday");
        end_of_day("R8 write");
        new_day(8'h01, 8'h05, 8'h02); tk("R4 30-day month end");

        // R4 February non-leap
        wr(3'd5, 8'h23, "R8 year write");
        wr(3'd4, 8'h02, "R8 month write");
        wr(3'd3, 8'h28, "R8 date write");
        end_of_day("R8 write");
        new_day(8'h01, 8'h03, 8'h03); tk("R4 February 28 in non-leap year");

        // R5 leap year 24
        wr(3'd5, 8'h24, "R8 year write");
        wr(3'd4, 8'h02, "R8 month write");
        wr(3'd3, 8'h28, "R8 date write");
        end_of_day("R8 write");
        new_day(8'h29, 8'h02, 8'h04); tk("R5 February 29 in year 24");
        end_of_day("R8 write");
        new_day(8'h01, 8'h03, 8'h05); tk("R5 leap February end");

        // R5 year 00 is leap
        wr(3'd5, 8'h00, "R8 year write");
        wr(3'd4, 8'h02, "R8 month write");
        wr(3'd3, 8'h28, "R8 date write");
        end_of_day("R8 write");
        new_day(8'h29, 8'h02, 8'h06); tk("R5 February 29 in year 00");

        // R6 year and century wrap, R7 weekday 6 to 0
        wr(3'd7, 8'h19, "R8 century write");
        wr(3'd5, 8'h99, "R8 year write");
        wr(3'd4, 8'h12, "R8 month write");
        wr(3'd3, 8'h31, "R8 date write");
        end_of_day("R8 write");
        new_day(8'h01, 8'h01, 8'h00); e[5] = 8'h00; e[7] = 8'h20;
        tk("R6 R7 year wrap steps century and weekday wraps");

        // R6 century 20 holds
        wr(3'd5, 8'h99, "R8 year write");
        wr(3'd4, 8'h12, "R8 month write");
        wr(3'd3, 8'h31, "R8 date write");
        end_of_day("R8 write");
        new_day(8'h01, 8'h01, 8'h01); e[5] = 8'h00;
        tk("R6 century 20 holds on year wrap");

        // R10 out-of-range date recovers
        wr(3'd5, 8'h23, "R8 year write");
        wr(3'd4, 8'h02, "R8 month write");
        wr(3'd3, 8'h31, "R8 date write");
        end_of_day("R8 write");
        new_day(8'h01, 8'h03, 8'h02); tk("R10 oversize date rolls over");

        // R9 same-cycle write and tick
        wr(3'd0, 8'h59, "R8 write");
        e[0] = 8'h00; e[1] = 8'h10;
        drive(1'b1, 1'b1, 3'd1, 8'h10, "R9 minutes write wins over carry");
        e[0] = 8'h30;
        drive(1'b1, 1'b1, 3'd0, 8'h30, "R9 seconds write ignores tick");
        wr(3'd0, 8'h59, "R8 write");
        e[0] = 8'h20;
        drive(1'b1, 1'b1, 3'd0, 8'h20, "R9 written seconds pass no carry");

        // R8 masks on hours and weekday
        wr(3'd2, 8'hE3, "R8 hours write mask");
        wr(3'd6, 8'hFD, "R8 weekday write mask");
        drive(1'b0, 1'b0, 3'd0, 8'h00, "R2 idle hold after writes");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule